// File: doc/BRIEF.md
# Ethernet Receive Length-Error Statistics Unit

This unit sits beside an Ethernet receive path and keeps three error statistics counters fed from a per-frame summary. When a frame ends, the receive path raises a one-cycle end-of-frame strobe together with the frame byte length, a CRC-good flag and an address-filter-pass flag. The length counts every byte from the first destination-address byte through the last CRC byte. The unit sorts the frame into three classes. A fragment is a frame shorter than 64 bytes with a bad CRC. An oversize frame is longer than 1522 bytes, whatever its CRC. A jabber frame is longer than 1522 bytes and has a bad CRC. It counts a frame only when the frame passed address filtering and the receiver is enabled.

The frame summary input has no back-pressure. The unit accepts every strobe in the cycle it arrives and classifies at most one frame per cycle, so there is no ready signal. Software reads a counter through a small read port: a one-cycle read request with a counter select. The value comes back one cycle later. Each read clears the counter it returns. Counters saturate at all ones and do not wrap.

Top module: `rxlen_err_stats`

## Requirements
- R1: After reset every counter reads 0 and `rd_valid` is low.
- R2: A counted frame whose length is below 64 bytes and whose `crc_ok` is low adds one to the fragment counter. A 64-byte frame with a bad CRC, or a short frame with a good CRC, adds nothing.
- R3: A counted frame whose length is above 1522 bytes adds one to the oversize counter, whatever its CRC. A frame of exactly 1522 bytes adds nothing.
- R4: A counted frame above 1522 bytes with `crc_ok` low adds one to the jabber counter, and in the same cycle adds one to the oversize counter.
- R5: A strobe with `addr_pass` low or `rx_en` low changes no counter.
- R6: A counter that holds all ones stays at all ones when further events arrive.
- R7: A read clears the selected counter to 0. If an event for that counter arrives in the same cycle as the read, the counter restarts at 1 and the read returns the value it held before.
- R8: `rd_addr` selects the counter: 0 for fragment, 1 for oversize, 2 for jabber, and 3 returns 0. `rd_data` and `rd_valid` are registered and appear in the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eof_valid | input | 1 | One-cycle end-of-frame strobe; qualifies the summary inputs |
| frm_len | input | LEN_W | Frame length in bytes, destination address through CRC |
| crc_ok | input | 1 | High when the frame CRC was correct |
| addr_pass | input | 1 | High when the frame passed address filtering |
| rx_en | input | 1 | Receiver enable; no counting while low |
| rd_en | input | 1 | Read request; clears the selected counter |
| rd_addr | input | 2 | Counter select |
| rd_valid | output | 1 | High one cycle after `rd_en` |
| rd_data | output | CNT_W | Counter value read |

## Verification
A strobe sampled at clock edge k updates the counter at that same edge. A read request sampled at edge k+1 or later therefore sees the new value, and `rd_data` carries it after edge k+1. The bench drives each stimulus at a falling edge. It issues the read on the following cycle and samples `rd_data` and `rd_valid` at the next falling edge, half a cycle after the registering edge. For the case where an event and a read land in the same cycle, both are driven at the same falling edge. The returned value must be the old count, and a second read one cycle later must return 1.

// File: rtl/rxlen_pkg.sv
package rxlen_pkg;
  localparam int NUM_CNT  = 3;
  localparam int SEL_W    = 2;
  localparam int IDX_FRAG = 0;
  localparam int IDX_OVER = 1;
  localparam int IDX_JAB  = 2;
endpackage

// File: rtl/rxlen_classify.sv
module rxlen_classify
  import rxlen_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1522
) (
  input  logic               eof_valid,
  input  logic [LEN_W-1:0]   frm_len,
  input  logic               crc_ok,
  input  logic               addr_pass,
  input  logic               rx_en,
  output logic [NUM_CNT-1:0] ev
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  logic take;
  logic is_short;
  logic is_long;

  always_comb begin
    take     = eof_valid && addr_pass && rx_en;
    is_short = frm_len < MIN_L;
    is_long  = frm_len > MAX_L;
    ev           = '0;
    ev[IDX_FRAG] = take && is_short && !crc_ok;
    ev[IDX_OVER] = take && is_long;
    ev[IDX_JAB]  = take && is_long && !crc_ok;
  end
endmodule

// File: rtl/rxlen_counter.sv
module rxlen_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt;
    if (clr)                     cnt_nx = inc ? ONE : '0;
    else if (inc && cnt != ALL1) cnt_nx = cnt + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end

  p_restart_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr && inc |=> cnt == ONE);
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !inc |=> cnt == '0);
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && cnt == ALL1 |=> cnt == ALL1);
  p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + ONE));
endmodule

// File: rtl/rxlen_err_stats.sv
module rxlen_err_stats
  import rxlen_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1522
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eof_valid,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             crc_ok,
  input  logic             addr_pass,
  input  logic             rx_en,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] rd_addr,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data
);
  logic [NUM_CNT-1:0] ev;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];
  logic [CNT_W-1:0]   rd_mux;

  rxlen_classify #(
    .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
  ) u_classify (
    .eof_valid(eof_valid), .frm_len(frm_len), .crc_ok(crc_ok),
    .addr_pass(addr_pass), .rx_en(rx_en), .ev(ev)
  );

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    logic clr_i;
    assign clr_i = rd_en && (rd_addr == SEL_W'(gi));
    rxlen_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(ev[gi]), .clr(clr_i), .cnt(cnt_q[gi])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (rd_addr == SEL_W'(i)) rd_mux = cnt_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  p_jab_is_over_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev[IDX_JAB] |-> ev[IDX_OVER]);
  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en || !addr_pass || !eof_valid) |-> ev == '0);
  p_frag_not_long_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev[IDX_FRAG] && ev[IDX_OVER]));
  p_rd_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid && $stable(rd_data));
endmodule

// File: tb/rxlen_err_stats_bench.sv
module rxlen_err_stats_bench;
  localparam int CW = 4;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          eof_valid = 1'b0;
  logic [LW-1:0] frm_len = '0;
  logic          crc_ok = 1'b1;
  logic          addr_pass = 1'b1;
  logic          rx_en = 1'b1;
  logic          rd_en = 1'b0;
  logic [1:0]    rd_addr = '0;
  logic          rd_valid;
  logic [CW-1:0] rd_data;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rxlen_err_stats #(.CNT_W(CW), .LEN_W(LW)) u_rxlen_err_stats (
    .clk(clk), .rst_n(rst_n), .eof_valid(eof_valid), .frm_len(frm_len),
    .crc_ok(crc_ok), .addr_pass(addr_pass), .rx_en(rx_en),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // {req[3:0], len[15:0], crc_ok, addr_pass, rx_en, exp_frag, exp_over, exp_jab}
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {4'd2, 16'd63,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 short bad crc
    {4'd2, 16'd64,   1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 64 bytes not short
    {4'd2, 16'd40,   1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 short good crc
    {4'd3, 16'd1522, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 max is legal
    {4'd3, 16'd1523, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 one over
    {4'd3, 16'd2000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 long good
    {4'd4, 16'd1523, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R4 jabber + oversize
    {4'd4, 16'd9000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R4 very long bad
    {4'd5, 16'd63,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 filtered out
    {4'd5, 16'd2000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 receiver off
    {4'd5, 16'd10,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 both off
    {4'd3, 16'd500,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}  // R3 normal frame
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int len, input bit crc, input bit ap, input bit en);
    @(negedge clk);
    eof_valid = 1'b1; frm_len = LW'(len); crc_ok = crc; addr_pass = ap; rx_en = en;
    @(negedge clk);
    eof_valid = 1'b0; addr_pass = 1'b1; rx_en = 1'b1; crc_ok = 1'b1;
  endtask

  task automatic rd(input int sel, output int val, output bit vld);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 2'(sel);
    @(negedge clk);
    rd_en = 1'b0;
    val = int'(rd_data); vld = rd_valid;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int v;
    bit vb;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rd_valid", int'(rd_valid), 0);
    rst_n = 1'b1;
    for (int s = 0; s < 3; s++) begin
      rd(s, v, vb);
      check("R1 reset count", v, 0);
    end
    check("R8 rd_valid after read", int'(vb), 1);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] w;
      string tag;
      w = VEC[i];
      tag = $sformatf("R%0d vec%0d", int'(w[25:22]), i);
      send(int'(w[21:6]), w[5], w[4], w[3]);
      rd(0, v, vb); check({tag, " frag"}, v, int'(w[2]));
      rd(1, v, vb); check({tag, " over"}, v, int'(w[1]));
      rd(2, v, vb); check({tag, " jab"},  v, int'(w[0]));
    end

    // R8 unused select returns 0 even with counters non-zero
    send(30, 1'b0, 1'b1, 1'b1);
    rd(3, v, vb);
    check("R8 select 3", v, 0);
    check("R8 valid", int'(vb), 1);
    @(negedge clk);
    check("R8 valid drops", int'(rd_valid), 0);
    rd(0, v, vb);
    check("R8 select 3 left fragment intact", v, 1);

    // R7 read and event in the same cycle
    repeat (3) send(20, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 2'd0;
    eof_valid = 1'b1; frm_len = 16'd20; crc_ok = 1'b0;
    @(negedge clk);
    rd_en = 1'b0; eof_valid = 1'b0; crc_ok = 1'b1;
    check("R7 read returns old", int'(rd_data), 3);
    rd(0, v, vb);
    check("R7 restart at 1", v, 1);
    rd(0, v, vb);
    check("R7 cleared", v, 0);

    // R6 saturation
    for (int k = 0; k < 20; k++) send(3000, 1'b0, 1'b1, 1'b1);
    rd(1, v, vb);
    check("R6 oversize saturates", v, 15);
    rd(2, v, vb);
    check("R6 jabber saturates", v, 15);
    rd(2, v, vb);
    check("R7 clear after saturation", v, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule